// File: doc/BRIEF.md
# Sampled PI Current Regulator with PWM Tick Output

This block closes a current loop for a buck converter. Each time a new signed inductor-current sample arrives, it runs one step of a proportional-integral control law in signed Q16.16 fixed point. It then saturates the controller output to a duty cycle between 0.0 and 1.0. The duty is re-expressed as an unsigned Q1.15 value and scaled by the PWM period to give a whole number of PWM ticks. The tick count appears together with a one-cycle valid strobe that a PWM generator can latch.

Runtime settings arrive on a separate valid/ready channel: the current setpoint, the two gains and the sampling period in nanoseconds. When they are loaded, the block converts the period to seconds and folds it into the integral gain, so that each sample costs no extra multiply. The PWM period is a plain static input with no handshake.

The datapath is sequenced and not pipelined. A sample's result is always presented before the next sample can be accepted, so a closed loop never waits for later data to push a result out.

Top module: `pi_current_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the integrator, the loaded settings and the tick output, and deasserts the output valid. After reset both ready outputs are high.
- R2: The measured current in Q16.16 amperes equals the raw signed sample times the constant gain `CUR_GAIN` (default 256, i.e. 1/256 A per code), with no offset subtracted. With Kp = 1.0 (0x0001_0000), Ki = 0, setpoint 0 and period 1000, a raw code of -128 yields 500 ticks.
- R3: On loading settings, the nanosecond period is converted to Q0.32 seconds as floor(ns * 4503600 / 2^20), clamped to 2^32-1, and the integral step gain is floor(Ki * that / 2^32). The per-sample integrator increment is floor(stepGain * error / 2^16).
- R4: A sample is accepted only in a cycle with `sampleValid` and `sampleReady` both high. `sampleReady` is low from the cycle after an acceptance until the result is emitted. When `paramValid` is high while idle, the settings are taken and the sample is not.
- R5: `dutyValid` is high for exactly one cycle, five clock edges after the accepting edge (four cycles of latency after the acceptance cycle). `dutyTicks` holds its value between results.
- R6: The controller output u = Kp*error + integrator is clamped to [0, 1.0]. A negative u gives 0 ticks. A u of 1.0 or more gives exactly the PWM period.
- R7: The clamped duty is truncated to Q1.15, multiplied by the 16-bit period, and the 15 fractional bits are discarded by truncation. With Kp = 1.0, setpoint 0, period 1000 and raw code -1, the result is 3 ticks.
- R8: Anti-windup: when u was outside [0, 1.0] and the sign bit of the error equals the sign bit of the integrator, the integrator keeps its value; otherwise it adds the increment.
- R9: Every product, sum and the integrator saturate to the signed 32-bit range instead of wrapping. With Kp = 16384.0 and an error of 2 A, the output is the full period.
- R10: The PWM period input is sampled when the tick count is formed, with no handshake. A changed period applies to the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| paramValid | input | 1 | Settings word is valid |
| paramReady | output | 1 | Settings can be taken (idle) |
| refCurrent | input | 32 | Current setpoint, signed Q16.16 amperes |
| gainP | input | 32 | Proportional gain, signed Q16.16 |
| gainI | input | 32 | Integral gain, signed Q16.16 per second |
| sampleTimeNs | input | 32 | Sampling period, unsigned nanoseconds |
| sampleValid | input | 1 | Current sample is valid |
| sampleReady | output | 1 | Sample can be taken |
| curRaw | input | 16 | Raw signed current ADC code |
| pwmPeriod | input | 16 | PWM period in ticks, static |
| dutyTicks | output | 16 | Duty cycle in PWM ticks |
| dutyValid | output | 1 | One-cycle strobe marking a new tick count |

## Verification
The embedded properties watch on every cycle that the valid strobe is a single pulse at the fixed latency after acceptance, and that the sequencer refuses samples while busy. They also check that the Q1.15 duty never exceeds 1.0, that the tick count stays within the period, that a held integrator does not move, and that a non-negative increment never lowers the integrator. The numeric content cannot be seen by any local property: the scaling and setting conversion, the clamp points, truncation, and whether anti-windup releases at the right sample. The bench's behavioural model covers these by running wind-up, reversal, overflow and period-change scenarios and comparing every output cycle.

// File: rtl/pi_ctrl_pkg.sv
package pi_ctrl_pkg;

  // strobes the sequencer hands to the datapath, one per step
  typedef struct packed {
    logic takeParam;
    logic convTs;
    logic scaleKi;
    logic takeSample;
    logic calcErr;
    logic calcTerms;
    logic calcOut;
    logic emit;
  } piStrobe_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TS,
    PH_KI,
    PH_ERR,
    PH_TERM,
    PH_OUT,
    PH_EMIT
  } piPhase_t;

endpackage

// File: rtl/pi_ctrl_seq.sv
module pi_ctrl_seq
  import pi_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      paramValid,
  input  logic      sampleValid,
  output logic      paramReady,
  output logic      sampleReady,
  output piStrobe_t strobe
);

  piPhase_t phase, phaseNext;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phaseNext;
  end

  always_comb begin
    strobe    = '0;
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: begin
        if (paramValid) begin
          strobe.takeParam = 1'b1;
          phaseNext        = PH_TS;
        end else if (sampleValid) begin
          strobe.takeSample = 1'b1;
          phaseNext         = PH_ERR;
        end
      end
      PH_TS:   begin strobe.convTs    = 1'b1; phaseNext = PH_KI;   end
      PH_KI:   begin strobe.scaleKi   = 1'b1; phaseNext = PH_IDLE; end
      PH_ERR:  begin strobe.calcErr   = 1'b1; phaseNext = PH_TERM; end
      PH_TERM: begin strobe.calcTerms = 1'b1; phaseNext = PH_OUT;  end
      PH_OUT:  begin strobe.calcOut   = 1'b1; phaseNext = PH_EMIT; end
      PH_EMIT: begin strobe.emit      = 1'b1; phaseNext = PH_IDLE; end
      default: phaseNext = PH_IDLE;
    endcase
  end

  assign paramReady  = (phase == PH_IDLE);
  assign sampleReady = (phase == PH_IDLE) && !paramValid;

  // R4: once a sample is taken, no further sample is offered a slot
  a_r4_busy_blocks_sample: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && sampleReady) |=> !sampleReady);

  // R5: the emit step follows acceptance after a fixed number of steps
  a_r5_emit_step: assert property (@(posedge clk) disable iff (rst)
    $past(sampleValid && sampleReady, 4) |-> strobe.emit);

endmodule

// File: rtl/pi_ctrl_path.sv
module pi_ctrl_path
  import pi_ctrl_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int FRAC_W   = 16,
  parameter int SMP_W    = 16,
  parameter int TICK_W   = 16,
  parameter int CUR_GAIN = 256,
  parameter int NS_SCALE = 4503600,
  parameter int NS_SHIFT = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  piStrobe_t                strobe,
  input  logic signed [ACC_W-1:0]  refCurrent,
  input  logic signed [ACC_W-1:0]  gainP,
  input  logic signed [ACC_W-1:0]  gainI,
  input  logic        [ACC_W-1:0]  sampleTimeNs,
  input  logic signed [SMP_W-1:0]  curRaw,
  input  logic        [TICK_W-1:0] pwmPeriod,
  output logic        [TICK_W-1:0] dutyTicks,
  output logic                     dutyValid
);

  localparam int PROD_W     = 2 * ACC_W;
  localparam int WIDE_W     = PROD_W + 1;
  localparam int DUTY_FRAC  = TICK_W - 1;
  localparam int DUTY_SHIFT = FRAC_W - DUTY_FRAC;

  localparam logic signed [WIDE_W-1:0] ACC_MAX =
    {{(WIDE_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] ACC_MIN =
    {{(WIDE_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] UNITY =
    {{(ACC_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};
  localparam logic [TICK_W-1:0] DUTY_ONE =
    {1'b1, {DUTY_FRAC{1'b0}}};
  localparam logic signed [WIDE_W-1:0] GAIN_W = WIDE_W'(CUR_GAIN);

  function automatic logic signed [ACC_W-1:0] clampAcc(input logic signed [WIDE_W-1:0] v);
    if (v > ACC_MAX)      clampAcc = ACC_MAX[ACC_W-1:0];
    else if (v < ACC_MIN) clampAcc = ACC_MIN[ACC_W-1:0];
    else                  clampAcc = v[ACC_W-1:0];
  endfunction

  // settings
  logic signed [ACC_W-1:0] refR, kpR, kiR, kiDtR;
  logic        [ACC_W-1:0] tsNsR, tsQR;
  // per-sample state
  logic signed [SMP_W-1:0] rawR;
  logic signed [ACC_W-1:0] errR, pTermR, incR, integR;
  logic        [TICK_W-1:0] dutyR, ticksR;
  logic                     validR;

  // combinational next values
  logic        [PROD_W-1:0] tsProd, tsShift;
  logic        [ACC_W-1:0]  tsQNext;
  logic signed [ACC_W-1:0]  kiDtNext, errNext, pNext, incNext, integNext;
  logic signed [WIDE_W-1:0] measW;
  logic signed [ACC_W-1:0]  uAcc, uSat;
  logic                     satFlag, hold;
  logic        [TICK_W-1:0] dutyNext, ticksNext;
  logic        [2*TICK_W-1:0] tickProd;

  always_comb begin
    // nanoseconds to Q0.32 seconds
    tsProd  = PROD_W'(tsNsR) * PROD_W'(NS_SCALE);
    tsShift = tsProd >> NS_SHIFT;
    tsQNext = (|tsShift[PROD_W-1:ACC_W]) ? '1 : tsShift[ACC_W-1:0];
    // integral gain folded with the period
    kiDtNext = clampAcc((WIDE_W'(kiR) * WIDE_W'($signed({1'b0, tsQR}))) >>> ACC_W);
    // error from scaled sample
    measW   = WIDE_W'(rawR) * GAIN_W;
    errNext = clampAcc(WIDE_W'(refR) - measW);
    // proportional term and integrator increment
    pNext   = clampAcc((WIDE_W'(kpR) * WIDE_W'(errR)) >>> FRAC_W);
    incNext = clampAcc((WIDE_W'(kiDtR) * WIDE_W'(errR)) >>> FRAC_W);
    // output clamp
    uAcc = clampAcc(WIDE_W'(pTermR) + WIDE_W'(integR));
    if (uAcc < 0) begin
      uSat    = '0;
      satFlag = 1'b1;
    end else if (uAcc > UNITY) begin
      uSat    = UNITY;
      satFlag = 1'b1;
    end else begin
      uSat    = uAcc;
      satFlag = 1'b0;
    end
    dutyNext  = TICK_W'(uSat >>> DUTY_SHIFT);
    // anti-windup on raw sign bits
    hold      = satFlag && (errR[ACC_W-1] == integR[ACC_W-1]);
    integNext = clampAcc(WIDE_W'(integR) + WIDE_W'(incR));
    // ticks from Q1.15 duty
    tickProd  = (2*TICK_W)'(dutyR) * (2*TICK_W)'(pwmPeriod);
    ticksNext = TICK_W'(tickProd >> DUTY_FRAC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      refR <= '0; kpR <= '0; kiR <= '0; tsNsR <= '0;
      tsQR <= '0; kiDtR <= '0; rawR <= '0; errR <= '0;
      pTermR <= '0; incR <= '0; integR <= '0;
      dutyR <= '0; ticksR <= '0; validR <= 1'b0;
    end else begin
      validR <= strobe.emit;
      if (strobe.takeParam) begin
        refR  <= refCurrent;
        kpR   <= gainP;
        kiR   <= gainI;
        tsNsR <= sampleTimeNs;
      end
      if (strobe.convTs)     tsQR  <= tsQNext;
      if (strobe.scaleKi)    kiDtR <= kiDtNext;
      if (strobe.takeSample) rawR  <= curRaw;
      if (strobe.calcErr)    errR  <= errNext;
      if (strobe.calcTerms) begin
        pTermR <= pNext;
        incR   <= incNext;
      end
      if (strobe.calcOut) begin
        dutyR <= dutyNext;
        if (!hold) integR <= integNext;
      end
      if (strobe.emit) ticksR <= ticksNext;
    end
  end

  assign dutyTicks = ticksR;
  assign dutyValid = validR;

  // R6: stored Q1.15 duty never above 1.0
  a_r6_duty_range: assert property (@(posedge clk) disable iff (rst)
    dutyR <= DUTY_ONE);

  // R8: a held step leaves the integrator untouched
  a_r8_hold_keeps_integ: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.calcOut && hold) |-> integR == $past(integR));

  // R8: integrator moves only in the output step
  a_r8_integ_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(strobe.calcOut) |-> $stable(integR));

  // R9: adding a non-negative increment never wraps the integrator downward
  a_r9_integ_no_wrap: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.calcOut && !hold && !incR[ACC_W-1]) |-> $signed(integR) >= $signed($past(integR)));

endmodule

// File: rtl/pi_current_ctrl.sv
module pi_current_ctrl
  import pi_ctrl_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int FRAC_W   = 16,
  parameter int SMP_W    = 16,
  parameter int TICK_W   = 16,
  parameter int CUR_GAIN = 256,
  parameter int NS_SCALE = 4503600,
  parameter int NS_SHIFT = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              paramValid,
  output logic              paramReady,
  input  logic [ACC_W-1:0]  refCurrent,
  input  logic [ACC_W-1:0]  gainP,
  input  logic [ACC_W-1:0]  gainI,
  input  logic [ACC_W-1:0]  sampleTimeNs,
  input  logic              sampleValid,
  output logic              sampleReady,
  input  logic [SMP_W-1:0]  curRaw,
  input  logic [TICK_W-1:0] pwmPeriod,
  output logic [TICK_W-1:0] dutyTicks,
  output logic              dutyValid
);

  piStrobe_t strobe;

  pi_ctrl_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .paramValid  (paramValid),
    .sampleValid (sampleValid),
    .paramReady  (paramReady),
    .sampleReady (sampleReady),
    .strobe      (strobe)
  );

  pi_ctrl_path #(
    .ACC_W    (ACC_W),
    .FRAC_W   (FRAC_W),
    .SMP_W    (SMP_W),
    .TICK_W   (TICK_W),
    .CUR_GAIN (CUR_GAIN),
    .NS_SCALE (NS_SCALE),
    .NS_SHIFT (NS_SHIFT)
  ) u_path (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .refCurrent   ($signed(refCurrent)),
    .gainP        ($signed(gainP)),
    .gainI        ($signed(gainI)),
    .sampleTimeNs (sampleTimeNs),
    .curRaw       ($signed(curRaw)),
    .pwmPeriod    (pwmPeriod),
    .dutyTicks    (dutyTicks),
    .dutyValid    (dutyValid)
  );

  // R5: valid is a single-cycle strobe
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    dutyValid |=> !dutyValid);

  // R5: result arrives a fixed number of edges after acceptance
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    $past(sampleValid && sampleReady, 5) |-> dutyValid);

  // R6: tick count never exceeds the period it was formed from
  a_r6_ticks_le_period: assert property (@(posedge clk) disable iff (rst)
    dutyValid |-> dutyTicks <= $past(pwmPeriod));

endmodule

// File: tb/tb_pi_current_ctrl.sv
`timescale 1ns/1ps
module tb_pi_current_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        paramValid = 1'b0;
  logic        paramReady;
  logic [31:0] refCurrent = '0, gainP = '0, gainI = '0, sampleTimeNs = '0;
  logic        sampleValid = 1'b0;
  logic        sampleReady;
  logic [15:0] curRaw = '0;
  logic [15:0] pwmPeriod = 16'd1000;
  logic [15:0] dutyTicks;
  logic        dutyValid;

  always #10 clk = ~clk;

  pi_current_ctrl dut (
    .clk(clk), .rst(rst),
    .paramValid(paramValid), .paramReady(paramReady),
    .refCurrent(refCurrent), .gainP(gainP), .gainI(gainI), .sampleTimeNs(sampleTimeNs),
    .sampleValid(sampleValid), .sampleReady(sampleReady), .curRaw(curRaw),
    .pwmPeriod(pwmPeriod), .dutyTicks(dutyTicks), .dutyValid(dutyValid)
  );

  int vectors = 0;
  int fails = 0;
  int cycPos = 0;
  int lastT = 0;
  bit finished = 0;

  typedef struct { int due; int ticks; string tag; } pend_t;
  pend_t pq[$];

  // behavioural model state
  longint mRef = 0, mKp = 0, mKiDt = 0, mInteg = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat32(longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  task automatic modelParams(longint r, longint kp, longint ki, longint tsNs);
    longint tsQ;
    tsQ = (tsNs * 64'sd4503600) >>> 20;
    if (tsQ > 64'sd4294967295) tsQ = 64'sd4294967295;
    mRef  = r;
    mKp   = kp;
    mKiDt = sat32((ki * tsQ) >>> 32);
  endtask

  function automatic int modelSample(longint raw);
    longint meas, err, p, inc, u, uSat, duty;
    bit sat, hold;
    meas = raw * 256;
    err  = sat32(mRef - meas);
    p    = sat32((mKp * err) >>> 16);
    inc  = sat32((mKiDt * err) >>> 16);
    u    = sat32(p + mInteg);
    if (u < 0)            begin uSat = 0;     sat = 1; end
    else if (u > 65536)   begin uSat = 65536; sat = 1; end
    else                  begin uSat = u;     sat = 0; end
    hold = sat && ((err < 0) == (mInteg < 0));
    if (!hold) mInteg = sat32(mInteg + inc);
    duty = uSat >>> 1;
    return int'((duty * longint'(pwmPeriod)) >>> 15);
  endfunction

  always @(posedge clk) cycPos++;

  // cycle-by-cycle comparison against the model's expected stream
  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit expV;
      string tg;
      while (pq.size() > 0 && pq[0].due < cycPos) void'(pq.pop_front());
      expV = (pq.size() > 0) && (pq[0].due == cycPos);
      chk(dutyValid == expV, "R5 valid timing", dutyValid, expV);
      tg = "R5 hold";
      if (expV) begin
        lastT = pq[0].ticks;
        tg    = pq[0].tag;
        void'(pq.pop_front());
      end
      chk(dutyTicks == lastT[15:0], tg, dutyTicks, lastT);
    end
  end

  task automatic sendParam(logic [31:0] r, logic [31:0] kp, logic [31:0] ki, logic [31:0] ts);
    @(negedge clk);
    paramValid = 1'b1; refCurrent = r; gainP = kp; gainI = ki; sampleTimeNs = ts;
    #1;
    while (!paramReady) begin @(negedge clk); #1; end
    modelParams(longint'($signed(r)), longint'($signed(kp)), longint'($signed(ki)), longint'({32'b0, ts}));
    @(negedge clk);
    paramValid = 1'b0;
  endtask

  task automatic sendSample(int raw, string tag, int hand = -1);
    int e;
    @(negedge clk);
    sampleValid = 1'b1; curRaw = 16'(raw);
    #1;
    while (!sampleReady) begin @(negedge clk); #1; end
    e = modelSample(longint'(raw));
    if (hand >= 0) e = hand;
    pq.push_back('{due: cycPos + 5, ticks: e, tag: tag});
    @(negedge clk);
    sampleValid = 1'b0;
    #1;
    chk(sampleReady == 1'b0, "R4 busy", sampleReady, 0);
  endtask

  task automatic waitIdle();
    repeat (10) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    pq.delete();
    lastT = 0; mRef = 0; mKp = 0; mKiDt = 0; mInteg = 0;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(dutyValid == 1'b0, "R1 valid after reset", dutyValid, 0);
    chk(dutyTicks == 16'd0, "R1 ticks after reset", dutyTicks, 0);
    chk(paramReady == 1'b1, "R1 paramReady", paramReady, 1);
    chk(sampleReady == 1'b1, "R1 sampleReady", sampleReady, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycPos, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    doReset();

    // R2 / R7: scaling, Q1.15 and truncation
    pwmPeriod = 16'd1000;
    sendParam(32'h0, 32'h0001_0000, 32'h0, 32'd10000);
    sendSample(-128, "R2 scaling", 500);
    sendSample(-1, "R7 truncation", 3);
    sendSample(0, "R7 zero", 0);

    // R6: clamp limits
    sendSample(256, "R6 negative clamp", 0);
    sendSample(-512, "R6 upper clamp", 1000);
    sendSample(-256, "R6 exact unity", 1000);
    waitIdle();

    // R3: period conversion into the integral step
    pwmPeriod = 16'd40000;
    sendParam(32'h0, 32'h0, 32'h0001_0000, 32'd1000000);
    sendSample(-128, "R3 first step", 0);
    sendSample(-128, "R3 second step", 19);
    sendSample(-128, "R3 third step");
    sendSample(-128, "R3 fourth step");
    waitIdle();

    // R8: wind-up against the clamp, then reversal
    pwmPeriod = 16'd1000;
    sendParam(32'h0005_0000, 32'h0, 32'h2710_0000, 32'd10000);
    for (int i = 0; i < 8; i++) sendSample(0, "R8 windup");
    for (int i = 0; i < 6; i++) sendSample(2560, "R8 release");
    for (int i = 0; i < 4; i++) sendSample(0, "R8 recover");
    waitIdle();

    // R9: saturating proportional product
    sendParam(32'h0002_0000, 32'h4000_0000, 32'h0, 32'd10000);
    sendSample(0, "R9 product saturates", 1000);
    sendSample(1024, "R9 negative extreme");
    waitIdle();

    // R1: reset clears integrator and settings mid-run
    doReset();
    sendSample(-128, "R1 cleared settings", 0);
    sendParam(32'h0, 32'h0001_0000, 32'h0, 32'd10000);
    sendSample(-128, "R1 cleared integrator", 500);
    waitIdle();

    // R10: period taken without handshake
    pwmPeriod = 16'd2000;
    sendSample(-128, "R10 period 2000", 1000);
    waitIdle();
    pwmPeriod = 16'd3000;
    sendSample(-128, "R10 period 3000", 1500);
    waitIdle();

    // R4: settings win over a simultaneous sample
    @(negedge clk);
    paramValid = 1'b1; sampleValid = 1'b1; curRaw = 16'hFF80;
    refCurrent = 32'h0; gainP = 32'h0000_8000; gainI = 32'h0; sampleTimeNs = 32'd10000;
    #1;
    chk(sampleReady == 1'b0, "R4 priority sampleReady", sampleReady, 0);
    chk(paramReady == 1'b1, "R4 priority paramReady", paramReady, 1);
    modelParams(0, 32768, 0, 10000);
    @(negedge clk);
    paramValid = 1'b0;
    #1;
    while (!sampleReady) begin @(negedge clk); #1; end
    pq.push_back('{due: cycPos + 5, ticks: modelSample(-128), tag: "R4 deferred sample"});
    @(negedge clk);
    sampleValid = 1'b0;
    // back-to-back requests with valid held
    sendSample(-256, "R4 back to back a");
    sendSample(-384, "R4 back to back b");
    waitIdle();

    finished = 1;
    chk(pq.size() == 0, "R5 all results seen", pq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule